// File: doc/BRIEF.md
# Iterative Carry-less Multiply Unit

This block multiplies two XLEN-bit operands over GF(2) for a 64-bit integer core. Partial products are merged with XOR, so no carry ever propagates. The 2·XLEN-bit product is built one multiplier bit per clock. When the last bit has been folded in, the unit returns one of three XLEN-bit windows of the product, selected by the instruction's 3-bit funct3 field, together with a one-cycle done strobe.

The low window suits general GF(2) arithmetic and the high window suits GHASH-style reductions. The reversed window, shifted down by one bit from the high window, lets bit-reflected CRC code save a multiply. The latency is the same for every operand pair. There is no early exit when the remaining multiplier bits are zero, so secret operands cannot be inferred from timing. A start that arrives while the unit is working is dropped. A start carrying an unrecognised funct3 is flagged on a separate strobe and produces no result.

Top module: `clmul_iter`

## Requirements
- R1: With funct3 = 3'b001 the result is bits XLEN-1:0 of the carry-less product of a_i and b_i.
- R2: With funct3 = 3'b011 the result is bits 2·XLEN-1:XLEN of the product, and its bit XLEN-1 is always 0.
- R3: With funct3 = 3'b010 the result is bits 2·XLEN-2:XLEN-1 of the product.
- R4: Partial products combine by XOR. For example, 3 times 3 gives 5, not 9.
- R5: An accepted start is the clock edge at which start_i is high while busy_o is low and funct3 is one of 001, 011 or 010. done_o is high for exactly one cycle, XLEN clock edges after that accepted start. This holds for every operand value, and busy_o is high from the accepted start until done_o rises.
- R6: A start_i pulse while busy_o is high is ignored: it does not change the pending result, does not produce an extra done_o, and does not raise illegal_o.
- R7: result_o changes only when done_o rises, and it holds its value until the next done_o.
- R8: A start while idle with any funct3 other than 001, 011 or 010 raises illegal_o for exactly one cycle, starting one edge after the start. It does not raise busy_o or done_o and leaves result_o unchanged.
- R9: After reset, busy_o, done_o and illegal_o are 0 and result_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled at the rising edge |
| funct3_i | input | 3 | Window select: 001 low, 011 high, 010 reversed |
| a_i | input | XLEN | Multiplicand |
| b_i | input | XLEN | Multiplier, consumed least significant bit first |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle result strobe |
| illegal_o | output | 1 | One-cycle strobe for a rejected funct3 |
| result_o | output | XLEN | Selected product window, held between strobes |

## Verification
A result is due XLEN edges after the edge that accepts its start, and an illegal flag is due one edge after its start. The driver notes the edge count at which it raises start_i. It queues the expected window together with an arrival time of that count plus one plus XLEN. The monitor samples on falling edges and compares both the value and the arrival edge of every done_o against the head of the queue. Any done_o that arrives when the queue is empty counts as a mismatch, which catches extra or repeated strobes. Illegal flags, ignored starts and result holding are checked inline on falling edges, one and several cycles after the stimulus.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  localparam logic [2:0] F3_LOW  = 3'b001;
  localparam logic [2:0] F3_HIGH = 3'b011;
  localparam logic [2:0] F3_REV  = 3'b010;

  typedef enum logic [1:0] {
    WIN_LOW  = 2'd0,
    WIN_HIGH = 2'd1,
    WIN_REV  = 2'd2,
    WIN_BAD  = 2'd3
  } win_e;

  function automatic win_e decode_funct3(input logic [2:0] f3);
    win_e w;
    case (f3)
      F3_LOW:  w = WIN_LOW;
      F3_HIGH: w = WIN_HIGH;
      F3_REV:  w = WIN_REV;
      default: w = WIN_BAD;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/clmul_ctrl.sv
module clmul_ctrl #(
  parameter int XLEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic legal_i,
  output logic busy_o,
  output logic accept_o,
  output logic reject_o,
  output logic step_o,
  output logic last_o
);
  localparam int CW = $clog2(XLEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(XLEN - 1);

  logic          busy_q;
  logic [CW-1:0] idx_q;
  logic          idle_start;

  assign idle_start = start_i && !busy_q;
  assign accept_o   = idle_start && legal_i;
  assign reject_o   = idle_start && !legal_i;
  assign step_o     = busy_q;
  assign last_o     = busy_q && (idx_q == LAST_IDX);
  assign busy_o     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (step_o) begin
      idx_q <= idx_q + 1'b1;
      if (last_o) busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/clmul_accum.sv
module clmul_accum #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [2*XLEN-1:0] prod_next_o
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]   a_sh_q;
  logic [XLEN-1:0] b_sh_q;
  logic [PW-1:0]   acc_q;
  logic [PW-1:0]   acc_next;

  function automatic logic [PW-1:0] fold_bit(input logic [PW-1:0] acc,
                                             input logic [PW-1:0] shifted_a,
                                             input logic          mbit);
    return acc ^ (mbit ? shifted_a : '0);
  endfunction

  assign acc_next    = fold_bit(acc_q, a_sh_q, b_sh_q[0]);
  assign prod_next_o = acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sh_q <= '0;
      b_sh_q <= '0;
      acc_q  <= '0;
    end else if (load_i) begin
      a_sh_q <= {{XLEN{1'b0}}, a_i};
      b_sh_q <= b_i;
      acc_q  <= '0;
    end else if (step_i) begin
      acc_q  <= acc_next;
      a_sh_q <= a_sh_q << 1;
      b_sh_q <= b_sh_q >> 1;
    end
  end
endmodule

// File: rtl/clmul_window.sv
module clmul_window
  import clmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [2*XLEN-1:0] prod_i,
  input  win_e              win_i,
  output logic [XLEN-1:0]   res_o
);
  logic [XLEN-1:0] low_w, high_w, rev_w;

  assign low_w  = prod_i[XLEN-1:0];
  assign high_w = prod_i[2*XLEN-1:XLEN];
  assign rev_w  = prod_i[2*XLEN-2:XLEN-1];

  always_comb begin
    case (win_i)
      WIN_HIGH: res_o = high_w;
      WIN_REV:  res_o = rev_w;
      default:  res_o = low_w;
    endcase
  end
endmodule

// File: rtl/clmul_iter.sv
module clmul_iter
  import clmul_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic [XLEN-1:0] result_o
);
  win_e              win_dec;
  win_e              win_q;
  logic              legal;
  logic              accept_fire;
  logic              reject_fire;
  logic              step_fire;
  logic              last_fire;
  logic [2*XLEN-1:0] prod_next;
  logic [XLEN-1:0]   window_val;
  logic              done_q;
  logic              illegal_q;
  logic [XLEN-1:0]   result_q;

  assign win_dec = decode_funct3(funct3_i);
  assign legal   = (win_dec != WIN_BAD);

  clmul_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .legal_i  (legal),
    .busy_o   (busy_o),
    .accept_o (accept_fire),
    .reject_o (reject_fire),
    .step_o   (step_fire),
    .last_o   (last_fire)
  );

  clmul_accum #(.XLEN(XLEN)) u_accum (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept_fire),
    .step_i      (step_fire),
    .a_i         (a_i),
    .b_i         (b_i),
    .prod_next_o (prod_next)
  );

  clmul_window #(.XLEN(XLEN)) u_window (
    .prod_i (prod_next),
    .win_i  (win_q),
    .res_o  (window_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= WIN_LOW;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      done_q    <= last_fire;
      illegal_q <= reject_fire;
      if (accept_fire) win_q <= win_dec;
      if (last_fire) result_q <= window_val;
    end
  end

  assign done_o    = done_q;
  assign illegal_o = illegal_q;
  assign result_o  = result_q;
endmodule

// File: rtl/clmul_iter_chk.sv
module clmul_iter_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            illegal_o,
  input logic [XLEN-1:0] result_o,
  input logic            accept_fire,
  input logic            reject_fire
);
  localparam int LW = $clog2(XLEN) + 2;

  logic          past_ok;
  logic          run_q;
  logic [LW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      run_q   <= 1'b0;
      lat_q   <= '0;
    end else begin
      past_ok <= 1'b1;
      if (accept_fire) begin
        run_q <= 1'b1;
        lat_q <= '0;
      end else if (run_q) begin
        lat_q <= lat_q + 1'b1;
        if (done_o) run_q <= 1'b0;
      end
    end
  end

  // R5: done arrives exactly XLEN edges after the accepting edge
  assert_done_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (run_q && lat_q == LW'(XLEN)));

  // R5: done is a single-cycle strobe
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: accepted start makes the unit busy
  assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fire |=> busy_o);

  // R6: start while busy raises no illegal flag
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !illegal_o);

  // R7: result holds between done strobes
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !done_o) |-> $stable(result_o));

  // R8: rejected start flags illegal without busy
  assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reject_fire |=> (illegal_o && !busy_o && !done_o));

  // R8: illegal and done never coincide
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(illegal_o && done_o));
endmodule

bind clmul_iter clmul_iter_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .result_o    (result_o),
  .accept_fire (accept_fire),
  .reject_fire (reject_fire)
);

// File: tb/clmul_iter_bench.sv
module clmul_iter_bench;
  localparam int XLEN = 64;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [XLEN-1:0] val;
    int              due;
    string           tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start_i = 1'b0;
  logic [2:0]      funct3_i = 3'b000;
  logic [XLEN-1:0] a_i = '0;
  logic [XLEN-1:0] b_i = '0;
  logic            busy_o, done_o, illegal_o;
  logic [XLEN-1:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  exp_t sb[$];
  logic [XLEN-1:0] last_res = '0;

  clmul_iter #(.XLEN(XLEN)) u_clmul_iter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .funct3_i(funct3_i),
    .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o),
    .illegal_o(illegal_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Reference: bitwise double loop over partial-product bits, XOR combine
  function automatic logic [XLEN-1:0] ref_window(input logic [XLEN-1:0] a,
                                                 input logic [XLEN-1:0] b,
                                                 input logic [2:0] f3);
    logic [2*XLEN-1:0] p = '0;
    for (int i = 0; i < XLEN; i++)
      for (int j = 0; j < XLEN; j++)
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
    if (f3 == 3'b011) return p[2*XLEN-1:XLEN];
    if (f3 == 3'b010) return p[2*XLEN-2:XLEN-1];
    return p[XLEN-1:0];
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: raises start for one edge; queues expectation for legal ops
  task automatic issue(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b,
                       input logic [2:0] f3, input string tag, input bit expect_res);
    exp_t e;
    @(negedge clk);
    a_i = a; b_i = b; funct3_i = f3; start_i = 1'b1;
    if (expect_res) begin
      e.val = ref_window(a, b, f3);
      e.due = cyc + 1 + XLEN;
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    start_i = 1'b0;
    a_i = ~a; b_i = ~b;
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: compares each done against the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (sb.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R6 unexpected done actual=1 expected=0 result=%h", result_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " value"}, result_o, e.val);
        check("R5 latency", XLEN'(cyc), XLEN'(e.due));
        last_res = e.val;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] held;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 busy", XLEN'(busy_o), '0);
    check("R9 done", XLEN'(done_o), '0);
    check("R9 illegal", XLEN'(illegal_o), '0);
    check("R9 result", result_o, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: 3 x 3 = 5 under XOR combining
    issue(64'd3, 64'd3, 3'b001, "R4 xor", 1'b1);
    check("R5 busy after accept", XLEN'(busy_o), XLEN'(1));
    wait_idle();
    check("R4 three-by-three", last_res, 64'd5);

    // R1 low window, several patterns
    issue(64'hDEADBEEF_01234567, 64'h0F0F_1234_8000_0001, 3'b001, "R1 low", 1'b1);
    wait_idle();
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001, "R1 low ones", 1'b1);
    wait_idle();

    // R2 high window, top bit always zero
    issue(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 3'b011, "R2 high", 1'b1);
    wait_idle();
    check("R2 top bit", XLEN'(result_o[XLEN-1]), '0);
    issue(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'b011, "R2 high msb", 1'b1);
    wait_idle();
    check("R2 msb product", result_o, 64'h4000_0000_0000_0000);

    // R3 reversed window
    issue(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 3'b010, "R3 rev msb", 1'b1);
    wait_idle();
    check("R3 msb product", result_o, 64'h8000_0000_0000_0000);
    issue(64'hC3A5_5A3C_9999_0001, 64'h1357_9BDF_2468_ACE0, 3'b010, "R3 rev", 1'b1);
    wait_idle();

    // R5 data independence: zero multiplier and full multiplier share latency
    issue(64'h1234_5678_9ABC_DEF0, 64'd0, 3'b001, "R5 zero multiplier", 1'b1);
    wait_idle();
    issue(64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b011, "R5 zero multiplicand", 1'b1);
    wait_idle();

    // R6: starts while busy are ignored (legal and illegal funct3)
    issue(64'hA5A5_A5A5_0000_FFFF, 64'h0000_0001_0000_0003, 3'b001, "R6 pending", 1'b1);
    repeat (10) @(negedge clk);
    issue(64'h1111, 64'h2222, 3'b011, "R6 ignored", 1'b0);
    check("R6 no illegal on busy start", XLEN'(illegal_o), '0);
    issue(64'h3333, 64'h4444, 3'b000, "R6 ignored bad", 1'b0);
    check("R6 no illegal on busy bad start", XLEN'(illegal_o), '0);
    wait_idle();

    // R7: result holds after done
    held = result_o;
    repeat (6) @(negedge clk);
    check("R7 hold", result_o, held);
    check("R7 hold matches last", result_o, last_res);

    // R8: illegal funct3 values 000 and 111
    issue(64'h5555, 64'h7777, 3'b000, "R8 f3=000", 1'b0);
    check("R8 illegal raised 000", XLEN'(illegal_o), XLEN'(1));
    check("R8 not busy 000", XLEN'(busy_o), '0);
    check("R8 result kept 000", result_o, held);
    @(negedge clk);
    check("R8 illegal one cycle", XLEN'(illegal_o), '0);
    issue(64'h5555, 64'h7777, 3'b111, "R8 f3=111", 1'b0);
    check("R8 illegal raised 111", XLEN'(illegal_o), XLEN'(1));
    repeat (XLEN + 8) @(negedge clk);
    check("R8 result kept after wait", result_o, held);
    check("R8 no pending", XLEN'(sb.size()), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule